// File: doc/BRIEF.md
# Low-Power Mode Sequencer

This block sequences the low-power states of a small 8-bit microcontroller. Software writes a four-bit power-control register. Bit 0 requests a light sleep and bit 1 requests a deep sleep. Bits 2 and 3 are two general flags that software can use for its own purposes. The block drives three enables. The CPU clock enable stops the core. The peripheral clock enable keeps interrupts, timers and the serial port running during light sleep. The oscillator enable stops the oscillator in deep sleep. A bus-hold output tells the pad logic to keep the address-latch and program-store strobes high and to freeze the port outputs while the core sleeps.

Any enabled interrupt request ends light sleep. Deep sleep ends only through the two external interrupt pins or the keyboard interrupt, and each of these must be enabled. Deep-sleep exit takes two steps:

- **Pin wake.** A low level on an enabled pin turns the oscillator back on. The exit finishes when that pin is released and the oscillator reports a valid clock.
- **Keyboard wake.** The block waits a fixed number of valid-clock cycles before it restarts the core.

When a deep-sleep exit finishes, the block reports which source woke it and sends a single-cycle pulse toward the interrupt controller.

A reset pin acts only after it has been held for a set number of consecutive cycles. The block itself runs on an always-on controller clock.

Top module: `pmode_ctrl`

## Requirements
- R1: In the run state, a write with bit 0 set and bit 1 clear puts the block in idle from the next cycle. In idle, cpu_clk_en=0, per_clk_en=1, osc_en=1, bus_hold=1, and reg_rdata bit 0 reads 1.
- R2: In idle, a high irq_pending ends idle at the next clock edge. After that edge, cpu_clk_en=1 and reg_rdata bit 0 reads 0.
- R3: In the run state, a write with bit 1 set puts the block in power-down from the next cycle, even when bit 0 is also set. In power-down, cpu_clk_en, per_clk_en and osc_en are all 0, and reg_rdata reads bit 1 set and bit 0 clear.
- R4: In power-down, the following have no effect and osc_en stays 0:
  - irq_pending;
  - a low level on an external pin whose enable is 0;
  - kbd_irq while kbd_en is 0.
- R5: In power-down, a low level on an enabled external pin (int0_n or int1_n) sets osc_en=1 from the next cycle. cpu_clk_en stays 0 for as long as the pin is held low.
- R6: A pin wake completes at the first clock edge at which both of these hold:
  - an armed pin has been released (now or earlier);
  - osc_valid=1.

  After that edge, cpu_clk_en=1, reg_rdata bit 1 reads 0, and wake_pulse is 1 for exactly one cycle.
- R7: When both pins are armed, the pin released first completes the exit and is reported as the wake source. If both pins are released in the same cycle, INT0 is reported.
- R8: A keyboard wake restores cpu_clk_en only after SETTLE_CYCLES (default 1024) clock edges with osc_valid=1. Cycles with osc_valid=0 do not count. If an enabled pin is low in the same cycle as the keyboard request, the pin wake is taken.
- R9: Bits 2 and 3 of reg_rdata read back as written, and they keep their values through idle and power-down.
- R10: wake_src is one-hot: bit 0 = INT0, bit 1 = INT1, bit 2 = keyboard. It is loaded when a power-down exit completes and is held until the next exit or a reset.
- R11: When rst_pin has been high for RST_HOLD (default 24) consecutive edges, core_rst is 1. The next edge returns the block to run with the register cleared and wake_src cleared. This reset takes precedence over an exit completing on that same edge. A shorter high period has no effect.
- R12: Register writes outside the run state are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin | input | 1 | Hardware reset pin, active high, held-time filtered |
| reg_we | input | 1 | Power-control register write strobe |
| reg_wdata | input | 4 | Write data: bit0 idle, bit1 power-down, bits 2-3 general flags |
| reg_rdata | output | 4 | Power-control register readback |
| irq_pending | input | 1 | Any enabled interrupt request |
| int0_n | input | 1 | External interrupt pin 0, active low |
| int1_n | input | 1 | External interrupt pin 1, active low |
| int0_en | input | 1 | Pin 0 enabled as a wake source |
| int1_en | input | 1 | Pin 1 enabled as a wake source |
| kbd_irq | input | 1 | Keyboard interrupt request |
| kbd_en | input | 1 | Keyboard interrupt enabled as a wake source |
| osc_valid | input | 1 | Oscillator reports a stable clock |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Interrupt/timer/serial clock enable |
| osc_en | output | 1 | Oscillator run enable |
| bus_hold | output | 1 | Hold strobes high and freeze port outputs |
| wake_src | output | 3 | One-hot source of the last power-down exit |
| wake_pulse | output | 1 | One-cycle pulse when a power-down exit completes |
| core_rst | output | 1 | Filtered reset toward the core |

## Verification
The filtered reset can mature on the same edge at which a pin-wake exit would complete. The bench provokes this by holding INT0 low through the 24-cycle reset window and releasing it just as core_rst rises. It judges the outcome by checking that the flag bits come back cleared, wake_src is zero and no wake pulse appears. The second coincidence is both armed pins released in one cycle, where the reported source must be INT0 alone.

// File: rtl/pmode_pkg.sv
package pmode_pkg;

  typedef enum logic [2:0] {
    ST_RUN,
    ST_IDLE,
    ST_PD,
    ST_PINWAKE,
    ST_KBDWAKE
  } pm_state_e;

  localparam int B_IDLE = 0;
  localparam int B_PD   = 1;
  localparam int B_GF0  = 2;
  localparam int B_GF1  = 3;

  // One-hot wake source: an earlier latched release wins, INT0 before INT1.
  function automatic logic [2:0] pick_src(input logic [1:0] early,
                                          input logic [1:0] now_rel);
    logic [1:0] s;
    s = (early != 2'b00) ? early : now_rel;
    if (s[0])      return 3'b001;
    else if (s[1]) return 3'b010;
    return 3'b000;
  endfunction

endpackage

// File: rtl/pmode_rstfilt.sv
module pmode_rstfilt #(
  parameter int HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_pin,
  output logic core_rst
);
  localparam int CW = $clog2(HOLD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!rst_pin)         cnt <= '0;
    else if (cnt != CW'(HOLD)) cnt <= cnt + 1'b1;
  end

  assign core_rst = (cnt == CW'(HOLD));

  AST_RST_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> $past(rst_pin)); // R11

endmodule

// File: rtl/pmode_settle.sv
module pmode_settle #(
  parameter int CYCLES = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic count_en,
  output logic done
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (start)                  cnt <= '0;
    else if (count_en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = count_en && (cnt == LAST);

endmodule

// File: rtl/pmode_seq.sv
module pmode_seq
  import pmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       core_rst,
  input  logic       reg_we,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       irq_pending,
  input  logic       int0_n,
  input  logic       int1_n,
  input  logic       int0_en,
  input  logic       int1_en,
  input  logic       kbd_irq,
  input  logic       kbd_en,
  input  logic       osc_valid,
  input  logic       settle_done,
  output logic       in_kbd,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       bus_hold,
  output logic [2:0] wake_src,
  output logic       wake_pulse
);
  pm_state_e  st;
  logic       idle_b, pd_b;
  logic [1:0] gf;
  logic [1:0] armed, rel_q;

  // Named events for the assertions
  logic [1:0] pin_low, rel_now;
  logic       wr_ok, kbd_req, pin_done, kbd_done, pd_exit;

  assign pin_low  = {int1_en & ~int1_n, int0_en & ~int0_n};
  assign rel_now  = armed & {int1_n, int0_n};
  assign wr_ok    = reg_we && (st == ST_RUN);
  assign kbd_req  = kbd_en && kbd_irq;
  assign pin_done = (st == ST_PINWAKE) && osc_valid && ((rel_q | rel_now) != 2'b00);
  assign kbd_done = (st == ST_KBDWAKE) && settle_done;
  assign pd_exit  = pin_done || kbd_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_RUN; idle_b <= 1'b0; pd_b <= 1'b0; gf <= 2'b00;
      armed <= 2'b00; rel_q <= 2'b00; wake_src <= 3'b000; wake_pulse <= 1'b0;
    end else if (core_rst) begin
      st <= ST_RUN; idle_b <= 1'b0; pd_b <= 1'b0; gf <= 2'b00;
      armed <= 2'b00; rel_q <= 2'b00; wake_src <= 3'b000; wake_pulse <= 1'b0;
    end else begin
      wake_pulse <= 1'b0;
      unique case (st)
        ST_RUN: if (wr_ok) begin
          idle_b <= reg_wdata[B_IDLE] & ~reg_wdata[B_PD];
          pd_b   <= reg_wdata[B_PD];
          gf     <= reg_wdata[B_GF1:B_GF0];
          if (reg_wdata[B_PD])        st <= ST_PD;
          else if (reg_wdata[B_IDLE]) st <= ST_IDLE;
        end
        ST_IDLE: if (irq_pending) begin
          idle_b <= 1'b0;
          st     <= ST_RUN;
        end
        ST_PD: begin
          if (pin_low != 2'b00) begin
            st    <= ST_PINWAKE;
            armed <= pin_low;
            rel_q <= 2'b00;
          end else if (kbd_req) begin
            st <= ST_KBDWAKE;
          end
        end
        ST_PINWAKE: begin
          if (pin_done) begin
            st         <= ST_RUN;
            pd_b       <= 1'b0;
            wake_src   <= pick_src(rel_q, rel_now);
            wake_pulse <= 1'b1;
          end else begin
            armed <= armed | pin_low;
            if (rel_q == 2'b00) rel_q <= rel_now;
          end
        end
        ST_KBDWAKE: if (kbd_done) begin
          st         <= ST_RUN;
          pd_b       <= 1'b0;
          wake_src   <= 3'b100;
          wake_pulse <= 1'b1;
        end
        default: st <= ST_RUN;
      endcase
    end
  end

  assign reg_rdata  = {gf, pd_b, idle_b};
  assign cpu_clk_en = (st == ST_RUN);
  assign per_clk_en = (st == ST_RUN) || (st == ST_IDLE);
  assign osc_en     = (st != ST_PD);
  assign bus_hold   = (st != ST_RUN);
  assign in_kbd     = (st == ST_KBDWAKE);

  AST_IDLE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && irq_pending && !core_rst) |=> (cpu_clk_en && !reg_rdata[B_IDLE])); // R2
  AST_PD_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD && pin_low == 2'b00 && !kbd_req && !core_rst) |=> !osc_en); // R4
  AST_PIN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PINWAKE && !pin_done && !core_rst) |=> (!cpu_clk_en && osc_en)); // R5
  AST_EXIT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_exit && !core_rst) |=> (wake_pulse && cpu_clk_en && !reg_rdata[B_PD])); // R6
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse); // R10
  AST_SRC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wake_src)); // R10
  AST_KBD_WAITS_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KBDWAKE && !osc_valid && !core_rst) |=> (st == ST_KBDWAKE)); // R8
  AST_GF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && !core_rst) |=> $stable(gf)); // R9
  AST_RST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |=> (cpu_clk_en && reg_rdata == 4'h0 && !wake_pulse)); // R11

endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl #(
  parameter int RST_HOLD      = 24,
  parameter int SETTLE_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rst_pin,
  input  logic       reg_we,
  input  logic [3:0] reg_wdata,
  output logic [3:0] reg_rdata,
  input  logic       irq_pending,
  input  logic       int0_n,
  input  logic       int1_n,
  input  logic       int0_en,
  input  logic       int1_en,
  input  logic       kbd_irq,
  input  logic       kbd_en,
  input  logic       osc_valid,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       osc_en,
  output logic       bus_hold,
  output logic [2:0] wake_src,
  output logic       wake_pulse,
  output logic       core_rst
);
  logic settle_done;
  logic in_kbd;

  pmode_rstfilt #(.HOLD(RST_HOLD)) u_rstfilt (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .core_rst(core_rst)
  );

  pmode_settle #(.CYCLES(SETTLE_CYCLES)) u_settle (
    .clk(clk), .rst_n(rst_n), .start(!in_kbd),
    .count_en(in_kbd && osc_valid), .done(settle_done)
  );

  pmode_seq u_seq (
    .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pending(irq_pending), .int0_n(int0_n), .int1_n(int1_n),
    .int0_en(int0_en), .int1_en(int1_en), .kbd_irq(kbd_irq), .kbd_en(kbd_en),
    .osc_valid(osc_valid), .settle_done(settle_done), .in_kbd(in_kbd),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .bus_hold(bus_hold), .wake_src(wake_src), .wake_pulse(wake_pulse)
  );

endmodule

// File: tb/pmode_ctrl_tb.sv
`timescale 1ns/1ps
module pmode_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_pin = 1'b0;
  logic       reg_we = 1'b0;
  logic [3:0] reg_wdata = 4'h0;
  logic [3:0] reg_rdata;
  logic       irq_pending = 1'b0;
  logic       int0_n = 1'b1, int1_n = 1'b1;
  logic       int0_en = 1'b0, int1_en = 1'b0;
  logic       kbd_irq = 1'b0, kbd_en = 1'b0;
  logic       osc_valid = 1'b1;
  logic       cpu_clk_en, per_clk_en, osc_en, bus_hold, wake_pulse, core_rst;
  logic [2:0] wake_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pmode_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pending(irq_pending),
    .int0_n(int0_n), .int1_n(int1_n), .int0_en(int0_en), .int1_en(int1_en),
    .kbd_irq(kbd_irq), .kbd_en(kbd_en), .osc_valid(osc_valid),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .bus_hold(bus_hold), .wake_src(wake_src), .wake_pulse(wake_pulse),
    .core_rst(core_rst)
  );

  // write data, expected readback, expected {cpu, per, osc}
  typedef struct packed {
    logic [3:0] wd;
    logic [3:0] rd;
    logic [2:0] en;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{4'h4, 4'h4, 3'b111},   // R9 flag 0
    '{4'hC, 4'hC, 3'b111},   // R9 both flags
    '{4'h0, 4'h0, 3'b111},   // R9 cleared
    '{4'h1, 4'h1, 3'b011},   // R1 idle
    '{4'h2, 4'h2, 3'b000},   // R3 power-down
    '{4'h3, 4'h2, 3'b000},   // R3 both bits: power-down wins
    '{4'h9, 4'h9, 3'b011},   // R1 idle with flag, R9
    '{4'h6, 4'h6, 3'b000}    // R3 power-down with flag, R9
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input int act, input int exp, input string tag);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] v);
    reg_we = 1'b1; reg_wdata = v;
    tick(1);
    reg_we = 1'b0;
  endtask

  task automatic wake_irq();
    irq_pending = 1'b1;
    tick(1);
    irq_pending = 1'b0;
  endtask

  task automatic wake_int0();
    int0_en = 1'b1; int0_n = 1'b0;
    tick(2);
    int0_n = 1'b1;
    tick(1);
    int0_en = 1'b0;
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    // reset state
    chk(reg_rdata, 0, "R11 reset rdata");
    chk({cpu_clk_en, per_clk_en, osc_en, bus_hold}, 4'b1110, "R11 reset enables");
    chk(wake_src, 0, "R10 reset wake_src");
    chk(core_rst, 0, "R11 reset core_rst");

    // vector table: write from run, check mode, return to run
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].wd);
      chk(reg_rdata, VEC[i].rd, "R1/R3/R9 table readback");
      chk({cpu_clk_en, per_clk_en, osc_en}, VEC[i].en, "R1/R3 table enables");
      chk(bus_hold, (VEC[i].en != 3'b111), "R1 table bus_hold");
      if (VEC[i].rd[1]) begin
        wake_int0();
        chk(wake_src, 3'b001, "R10 table wake source");
      end else if (VEC[i].rd[0]) begin
        wake_irq();
        chk(wake_pulse, 0, "R2 idle exit has no wake pulse");
      end
      chk(cpu_clk_en, 1, "R2/R6 table back to run");
      chk(reg_rdata, VEC[i].rd & 4'hC, "R9 flags kept through sleep");
    end

    // R12: write in idle ignored
    wr(4'h1);
    wr(4'hE);
    chk(reg_rdata, 4'h1, "R12 write in idle ignored");
    chk(cpu_clk_en, 0, "R12 still idle");
    wake_irq();
    chk(reg_rdata, 4'h0, "R2 idle bit cleared");

    // R4: power-down ignores non-wake sources
    wr(4'h2);
    irq_pending = 1'b1; kbd_irq = 1'b1; int1_n = 1'b0;
    tick(4);
    chk({osc_en, cpu_clk_en}, 0, "R4 power-down deaf");
    chk(reg_rdata, 4'h2, "R4 still power-down");
    irq_pending = 1'b0; kbd_irq = 1'b0; int1_n = 1'b1;

    // R5/R6: pin wake with delayed oscillator
    int0_en = 1'b1; int0_n = 1'b0;
    tick(1);
    chk({osc_en, cpu_clk_en}, 2'b10, "R5 oscillator restarts, cpu off");
    tick(5);
    chk(cpu_clk_en, 0, "R5 cpu off while pin held");
    osc_valid = 1'b0; int0_n = 1'b1;
    tick(3);
    chk(cpu_clk_en, 0, "R6 waits for valid oscillator");
    osc_valid = 1'b1;
    tick(1);
    chk({cpu_clk_en, wake_pulse, reg_rdata}, {2'b11, 4'h0}, "R6 exit complete");
    chk(wake_src, 3'b001, "R10 source INT0");
    tick(1);
    chk(wake_pulse, 0, "R6 pulse single cycle");
    chk(wake_src, 3'b001, "R10 source held");
    int0_en = 1'b0;

    // R7: first released pin wins
    int0_en = 1'b1; int1_en = 1'b1;
    wr(4'h2);
    int1_n = 1'b0; tick(1);
    int0_n = 1'b0; tick(1);
    int1_n = 1'b1; tick(1);
    chk(cpu_clk_en, 1, "R7 first release exits");
    chk(wake_src, 3'b010, "R7 source INT1");
    int0_n = 1'b1;
    tick(1);
    // R7: simultaneous release reports INT0
    wr(4'h2);
    int0_n = 1'b0; int1_n = 1'b0; tick(2);
    int0_n = 1'b1; int1_n = 1'b1; tick(1);
    chk(wake_src, 3'b001, "R7 simultaneous release INT0");
    int0_en = 1'b0; int1_en = 1'b0;

    // R8: keyboard settle count
    kbd_en = 1'b1;
    wr(4'h2);
    kbd_irq = 1'b1; osc_valid = 1'b0; tick(1); kbd_irq = 1'b0;
    chk({osc_en, cpu_clk_en}, 2'b10, "R8 keyboard restarts oscillator");
    tick(10);
    chk(cpu_clk_en, 0, "R8 no count without valid oscillator");
    osc_valid = 1'b1;
    tick(1023);
    chk(cpu_clk_en, 0, "R8 one cycle short of settle");
    tick(1);
    chk(cpu_clk_en, 1, "R8 settle done");
    chk({wake_src, wake_pulse}, {3'b100, 1'b1}, "R8/R10 keyboard source");
    // R8: pin beats keyboard
    int0_en = 1'b1;
    wr(4'h2);
    int0_n = 1'b0; kbd_irq = 1'b1; tick(1); kbd_irq = 1'b0;
    int0_n = 1'b1; tick(1);
    chk({cpu_clk_en, wake_src}, {1'b1, 3'b001}, "R8 pin wake preferred");
    kbd_en = 1'b0;

    // R11: short reset pulse ignored
    wr(4'h1);
    rst_pin = 1'b1; tick(10); rst_pin = 1'b0; tick(1);
    chk({core_rst, cpu_clk_en, reg_rdata}, {2'b00, 4'h1}, "R11 short reset ignored");
    wake_irq();
    // R11: full-length reset in idle
    wr(4'hD);
    rst_pin = 1'b1;
    tick(23);
    chk({core_rst, cpu_clk_en}, 2'b00, "R11 not yet reset");
    tick(1);
    chk(core_rst, 1, "R11 core_rst after hold");
    rst_pin = 1'b0;
    tick(1);
    chk({cpu_clk_en, reg_rdata}, {1'b1, 4'h0}, "R11 reset to run");

    // R11: reset and pin-wake exit on same edge
    wr(4'hE);
    int0_n = 1'b0; tick(1);
    rst_pin = 1'b1; tick(24);
    chk({core_rst, cpu_clk_en}, 2'b10, "R11 reset matured during wake");
    rst_pin = 1'b0; int0_n = 1'b1;
    tick(1);
    chk({cpu_clk_en, reg_rdata, wake_src, wake_pulse}, {1'b1, 4'h0, 3'b000, 1'b0},
        "R11 reset beats exit");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule